// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the control sequencer that sits between the converter's control register fields and a successive-approximation converter core. The core is seen only through a one-cycle launch pulse and a completion pulse. The sequencer decides when a conversion may begin. It latches the reference selection at the moment a start is accepted. When the selected reference is new, or has not settled since the converter was enabled, it inserts a timed settling phase first. It reports when an internal reference is ready for use and keeps a sticky completion flag that drives the interrupt request.

Conversions can be launched in three ways: by writing the start bit, by relaunching automatically in free-running mode, or by the processor halting in idle or noise-reduction sleep while the converter is set up for interrupt-driven single conversions. In free-running mode, a reference change cancels free-running operation at the end of the conversion in progress. The new reference is then settled and no further conversion is launched. Clearing the enable bit drops everything in progress and raises no completion flag.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, busy, ref_ready, irq_flag, irq_req and core_start are low and active_ref is 0.
- R2: A start write is accepted only when en is high and busy is low. busy rises on the clock edge that samples the write. A start write made while en is low or while busy is high has no effect.
- R3: active_ref takes the value of ref_sel only when a start is accepted, or at the end of a free-running conversion after a reference change. When the accepted start needs settling, core_start pulses exactly SETTLE_CYCLES cycles after busy rises. Settling is needed when the reference differs from active_ref or has not settled since enable.
- R4: A start accepted with an unchanged, already settled reference pulses core_start in the first cycle that busy is high.
- R5: The ref_sel codes 1, 2 and 3 select the three internal references (supply, 1.5 V, 1.6 V), and code 0 selects the external pin. ref_ready is high only while en is high, active_ref is internal, and the settling phase for that reference has completed.
- R6: busy stays high through settling and conversion, and falls on the edge that samples core_done in the converting phase. core_done outside a conversion has no effect.
- R7: irq_flag is set by a completed conversion and holds until irq_clr is sampled high. If both happen on the same edge, set wins. irq_req is irq_flag gated by irq_en.
- R8: With free_run high and the reference unchanged, each completion relaunches a conversion and busy stays high.
- R9: If ref_sel differs from active_ref when a free-running conversion completes, the block settles the new reference. ref_ready then rises, busy falls, and no further core_start pulse is issued.
- R10: A rising edge of cpu_halted starts a conversion when all of the following hold: sleep_mode is 1 (idle) or 2 (noise reduction), en and irq_en are high, free_run is low, and busy is low.
- R11: A rising edge of cpu_halted with sleep_mode 0 or 3, or with any other condition of R10 unmet, starts nothing.
- R12: Dropping en returns busy and ref_ready low on the next edge. No core_start pulse is issued afterwards, and the aborted conversion never sets irq_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Converter enable |
| ref_sel | input | 2 | Requested reference: 0 external pin, 1 supply, 2 1.5 V, 3 1.6 V |
| start_wr | input | 1 | One-cycle write of one to the start bit |
| free_run | input | 1 | Free-running mode |
| irq_en | input | 1 | Completion interrupt enable |
| irq_clr | input | 1 | One-cycle write of one to clear the completion flag |
| sleep_mode | input | 2 | 0 active, 1 idle, 2 noise reduction, 3 other sleep |
| cpu_halted | input | 1 | Processor has halted in its sleep state |
| core_done | input | 1 | Core completion pulse |
| core_start | output | 1 | One-cycle launch pulse to the core |
| busy | output | 1 | Start bit readback: settling or converting |
| active_ref | output | 2 | Reference currently applied to the core |
| ref_ready | output | 1 | Internal reference settled |
| irq_flag | output | 1 | Sticky completion flag |
| irq_req | output | 1 | Completion interrupt request |

## Verification
The bound checker watches these properties on every cycle:
- disabling clears busy and ref_ready at once;
- a start write made while busy leaves the applied reference untouched;
- an accepted start sets busy;
- the completion flag only appears after a completion pulse seen while busy, and it stays set until cleared;
- ref_ready only rises out of a busy settling phase.

Exact settling length, free-running relaunch and cancellation, the sleep-entry trigger conditions, and the absence of a flag after an abort are sequences. Only the bench scenarios can show these, and the bench compares them against its cycle model.

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] ref_sel,
  input  logic       start_wr,
  input  logic       free_run,
  input  logic       irq_en,
  input  logic       irq_clr,
  input  logic [1:0] sleep_mode,
  input  logic       cpu_halted,
  input  logic       core_done,
  output logic       core_start,
  output logic       busy,
  output logic [1:0] active_ref,
  output logic       ref_ready,
  output logic       irq_flag,
  output logic       irq_req
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);
  localparam logic [1:0] SLP_IDLE = 2'd1;
  localparam logic [1:0] SLP_QUIET = 2'd2;

  typedef enum logic [1:0] {IDLE, SETTLE, CONV} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          settled;
  logic          no_launch;
  logic          halt_q;

  wire sleep_ok = (sleep_mode == SLP_IDLE || sleep_mode == SLP_QUIET)
                  && cpu_halted && !halt_q && !free_run && irq_en;
  wire trig     = start_wr || sleep_ok;
  wire finish   = en && phase == CONV && core_done;
  wire ref_new  = ref_sel != active_ref;

  assign busy      = phase != IDLE;
  assign ref_ready = settled && active_ref != 2'd0;
  assign irq_req   = irq_flag && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= cpu_halted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (finish)  irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= IDLE;
      cnt        <= '0;
      settled    <= 1'b0;
      no_launch  <= 1'b0;
      active_ref <= 2'd0;
      core_start <= 1'b0;
    end else if (!en) begin
      phase      <= IDLE;
      settled    <= 1'b0;
      no_launch  <= 1'b0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      unique case (phase)
        IDLE: if (trig) begin
          if (ref_new || !settled) begin
            active_ref <= ref_sel;
            settled    <= 1'b0;
            no_launch  <= 1'b0;
            cnt        <= LOAD;
            phase      <= SETTLE;
          end else begin
            phase      <= CONV;
            core_start <= 1'b1;
          end
        end
        SETTLE: begin
          if (cnt == '0) begin
            settled <= 1'b1;
            if (no_launch) begin
              phase <= IDLE;
            end else begin
              phase      <= CONV;
              core_start <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CONV: if (core_done) begin
          if (!free_run) begin
            phase <= IDLE;
          end else if (ref_new) begin
            active_ref <= ref_sel;
            settled    <= 1'b0;
            no_launch  <= 1'b1;
            cnt        <= LOAD;
            phase      <= SETTLE;
          end else begin
            core_start <= 1'b1;
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] ref_sel,
  input logic       start_wr,
  input logic       free_run,
  input logic       irq_en,
  input logic       irq_clr,
  input logic [1:0] sleep_mode,
  input logic       cpu_halted,
  input logic       core_done,
  input logic       core_start,
  input logic       busy,
  input logic [1:0] active_ref,
  input logic       ref_ready,
  input logic       irq_flag,
  input logic       irq_req
);
  a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy && !ref_ready && !core_start);

  a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_wr && !core_done |=> $stable(active_ref));

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    en && start_wr && !busy |=> busy);

  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(core_done) && $past(busy) && $past(en));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag);

  a_r5_ready_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ready) |-> $past(busy));

  a_r5_ready_internal: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |-> active_ref != 2'd0);
endmodule

bind adc_start_seq adc_start_seq_chk u_chk (.*);

// File: tb/adc_start_seq_test.sv
module adc_start_seq_test;
  localparam int SET = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, start_wr = 0, free_run = 0, irq_en = 0, irq_clr = 0;
  logic cpu_halted = 0, core_done = 0;
  logic [1:0] ref_sel = 0, sleep_mode = 0;
  logic core_start, busy, ref_ready, irq_flag, irq_req;
  logic [1:0] active_ref;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_start_seq #(.SETTLE_CYCLES(SET)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_sel(ref_sel), .start_wr(start_wr),
    .free_run(free_run), .irq_en(irq_en), .irq_clr(irq_clr),
    .sleep_mode(sleep_mode), .cpu_halted(cpu_halted), .core_done(core_done),
    .core_start(core_start), .busy(busy), .active_ref(active_ref),
    .ref_ready(ref_ready), .irq_flag(irq_flag), .irq_req(irq_req));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: 0 idle, 1 settling, 2 converting
  int m_ph = 0, m_cnt = 0, m_ref = 0, m_set = 0, m_nol = 0, m_halt = 0, m_irq = 0, m_st = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ref = 0; m_set = 0; m_nol = 0; m_halt = 0; m_irq = 0; m_st = 0;
    end else begin
      int ph, cn, rf, st, nl, ss;
      bit trig;
      ph = m_ph; cn = m_cnt; rf = m_ref; st = m_set; nl = m_nol; ss = 0;
      trig = start_wr || ((sleep_mode == 1 || sleep_mode == 2) && cpu_halted && !m_halt
                          && !free_run && irq_en);
      if (en && m_ph == 2 && core_done) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (!en) begin ph = 0; st = 0; nl = 0; end
      else if (m_ph == 0 && trig) begin
        if (ref_sel != m_ref || !m_set) begin rf = ref_sel; st = 0; nl = 0; cn = SET - 1; ph = 1; end
        else begin ph = 2; ss = 1; end
      end else if (m_ph == 1) begin
        if (m_cnt == 0) begin st = 1; if (m_nol) ph = 0; else begin ph = 2; ss = 1; end end
        else cn = m_cnt - 1;
      end else if (m_ph == 2 && core_done) begin
        if (!free_run) ph = 0;
        else if (ref_sel != m_ref) begin rf = ref_sel; st = 0; nl = 1; cn = SET - 1; ph = 1; end
        else ss = 1;
      end
      m_ph = ph; m_cnt = cn; m_ref = rf; m_set = st; m_nol = nl; m_st = ss;
      m_halt = cpu_halted;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    cyc++;
    chk("R3 core_start", core_start, m_st);
    chk("R6 busy", busy, m_ph != 0);
    chk("R3 active_ref", active_ref, m_ref);
    chk("R5 ref_ready", ref_ready, m_set && m_ref != 0);
    chk("R7 irq_flag", irq_flag, m_irq);
    chk("R7 irq_req", irq_req, m_irq && irq_en);
  end

  // core model: completion three cycles after a launch
  int lat = -1;
  always @(negedge clk) begin
    if (!rst_n) begin lat = -1; core_done = 0; end
    else begin
      core_done = 0;
      if (core_start) lat = 3;
      else if (lat > 0) lat--;
      if (lat == 0) begin core_done = 1; lat = -1; end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_wr = 1; tick(); start_wr = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 500) begin tick(); g++; end
  endtask

  initial begin
    int n;
    tick(3); rst_n = 1; tick();
    chk("R1 busy", busy, 0); chk("R1 ready", ref_ready, 0); chk("R1 flag", irq_flag, 0);
    chk("R1 start", core_start, 0); chk("R1 ref", active_ref, 0);

    ref_sel = 2; pulse_start();
    chk("R2 start while disabled", busy, 0);

    en = 1; pulse_start();
    chk("R2 accepted", busy, 1); chk("R3 ref latched", active_ref, 2); chk("R5 not ready", ref_ready, 0);
    n = 0; while (!core_start && n < 100) begin tick(); n++; end
    chk("R3 settle length", n, SET); chk("R5 ready after settle", ref_ready, 1);
    wait_idle(); tick();
    chk("R6 busy cleared", busy, 0); chk("R7 flag set", irq_flag, 1); chk("R7 req gated", irq_req, 0);
    irq_en = 1; tick(); chk("R7 req", irq_req, 1);
    irq_clr = 1; tick(); irq_clr = 0; chk("R7 cleared", irq_flag, 0);

    pulse_start(); chk("R4 direct launch", core_start, 1);
    ref_sel = 3; pulse_start(); chk("R2 busy start ignored", active_ref, 2);
    wait_idle(); tick(2);
    chk("R3 no change while idle", active_ref, 2); chk("R5 still ready", ref_ready, 1);

    ref_sel = 2; free_run = 1; pulse_start();
    n = 0; for (int i = 0; i < 40; i++) begin if (core_start) n++; tick(); end
    chk("R8 relaunches", n >= 5, 1); chk("R8 busy held", busy, 1);
    while (!core_start) tick();
    ref_sel = 1; tick();
    n = 0; for (int i = 0; i < 40; i++) begin if (core_start) n++; tick(); end
    chk("R9 no launch", n, 0); chk("R9 idle", busy, 0);
    chk("R9 ref", active_ref, 1); chk("R9 ready", ref_ready, 1);
    free_run = 0; irq_clr = 1; tick(); irq_clr = 0;

    sleep_mode = 2; cpu_halted = 1; tick();
    chk("R10 sleep start", busy, 1); chk("R10 launch", core_start, 1);
    tick(); cpu_halted = 0; wait_idle(); tick();
    chk("R7 flag after wake", irq_flag, 1);
    irq_clr = 1; tick(); irq_clr = 0;

    sleep_mode = 3; cpu_halted = 1; tick(2); chk("R11 other sleep", busy, 0); cpu_halted = 0; tick();
    sleep_mode = 1; irq_en = 0; cpu_halted = 1; tick(2); chk("R11 irq disabled", busy, 0); cpu_halted = 0; tick();
    irq_en = 1; cpu_halted = 1; tick(); chk("R10 idle sleep start", busy, 1);
    cpu_halted = 0; wait_idle(); tick(); irq_clr = 1; tick(); irq_clr = 0; sleep_mode = 0;

    pulse_start(); tick(); en = 0; tick();
    chk("R12 busy dropped", busy, 0); chk("R12 ready dropped", ref_ready, 0);
    tick(10); chk("R12 no flag", irq_flag, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1; failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule